// File: doc/BRIEF.md
# Masked Content-Addressable Memory Core

This block is a small associative store. Each entry is a 64-bit word, and the host reaches every register through a 16-bit write port and a 16-bit read port. The host loads the search key as four 16-bit words. That key is compared in one cycle against every entry whose 2-bit state code marks it as active. The block then reports three results: whether any entry matched, whether more than one matched, and the lowest matching index. It also returns the bits of the matching entry that took no part in the compare, which serve as associated data.

Two 64-bit mask registers serve two purposes. A control field selects which masks hide bits from the compare. A second control field selects which masks protect bits of an entry from host writes. A third control field removes whole 16-bit words at the top of each entry from the compare, so those words act as an associated-data segment. A compare starts by itself when the host writes the key, a mask or the control register. The host can also start one with a command. The results are held until the next compare.

Each host address is a 3-bit group followed by a 2-bit word index. The groups are:

- 0: key.
- 1: mask A.
- 2: mask B.
- 3: control.
- 4: entry pointer.
- 5: entry data word at the pointer.
- 6: command on write, status on read.
- 7: state code of the entry at the pointer, read only.

Top module: `mcam_core`

## Requirements
- R1: After reset every entry holds state code 01 (Empty) and data zero. The key, both masks, the control register and the pointer are zero. Match, multiple-match, address and associated-data outputs are zero.
- R2: A write to group 0, 1 or 2 with word index k stores the data in bits [16k+15:16k] of the key, mask A or mask B. Group 3 stores the control word and group 4 stores the pointer. Each of these reads back unchanged from the same address.
- R3: A write to group 5 with word index k updates word k of the entry at the pointer, and that word reads back from group 5. Control bits [3:2] select the write mask: 0 none, 1 A, 2 B, 3 A OR B. Entry bits whose write-mask bit is 1 keep their old value.
- R4: A command write (group 6) with data[1:0]=01 sets the state code of the entry at the pointer to data[3:2]. The codes are 00 Valid, 01 Empty, 10 Skip and 11 RAM. Only Valid entries can match. Group 7 reads the code back in bits [1:0].
- R5: A write to groups 0 to 3 starts a compare, and so does a command with data[1:0]=00. The results appear one clock after the write is captured. They do not change at any other time, including on entry or state-code writes.
- R6: When at least one Valid entry matches, the match output is 1 and the address output is the lowest matching index.
- R7: The multiple-match output is 1 exactly when two or more Valid entries match.
- R8: Control bits [1:0] select the compare mask: 0 none, 1 A, 2 B, 3 A OR B. Bits set in the selected mask are ignored in the compare.
- R9: Control bits [5:4] give a count n from 0 to 3. The top n 16-bit words of every entry are left out of the compare.
- R10: On a match, the associated-data output carries the matching entry's bits that were not compared (from R8 or R9) and zeros in the compared bit positions.
- R11: When no entry matches, both flags, the address and the associated-data output are zero.
- R12: A read of group 6 returns status: bit 15 is the match flag, bit 14 is the multiple-match flag, bits [3:0] are the match address, and the other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 5 | Host write address: group [4:2], word index [1:0] |
| wr_data | input | 16 | Host write data |
| rd_addr | input | 5 | Host read address, same layout as the write address |
| rd_data | output | 16 | Host read data, combinational |
| match_o | output | 1 | At least one Valid entry matched |
| multi_o | output | 1 | Two or more Valid entries matched |
| match_addr_o | output | 4 | Lowest matching entry index |
| assoc_o | output | 64 | Uncompared bits of the matching entry |

## Verification
The hardest case to reach from the ports is a tie among several entries: identical data under the active masks, but different state codes. In that case the reported address and the multiple-match flag depend only on which entries are Valid. Random entry and key words are therefore drawn from a four-value pool, so that full 64-bit collisions happen often. Sparse random masks and split counts widen the set of entries that are equal under the mask. State codes are rewritten between compares, and directed steps pin down lowest-index priority, the write mask and the associated-data split.

// File: rtl/mcam_pkg.sv
package mcam_pkg;

   typedef enum logic [1:0] {
      ST_VALID = 2'b00,
      ST_EMPTY = 2'b01,
      ST_SKIP  = 2'b10,
      ST_RAM   = 2'b11
   } ent_state_e;

   localparam logic [2:0] GRP_KEY   = 3'd0;
   localparam logic [2:0] GRP_MSKA  = 3'd1;
   localparam logic [2:0] GRP_MSKB  = 3'd2;
   localparam logic [2:0] GRP_CTL   = 3'd3;
   localparam logic [2:0] GRP_PTR   = 3'd4;
   localparam logic [2:0] GRP_ENT   = 3'd5;
   localparam logic [2:0] GRP_CMD   = 3'd6;
   localparam logic [2:0] GRP_STATE = 3'd7;

   localparam logic [1:0] OP_SEARCH = 2'b00;
   localparam logic [1:0] OP_SETST  = 2'b01;

   // control word layout
   localparam int CTL_CSEL_LSB  = 0;
   localparam int CTL_WSEL_LSB  = 2;
   localparam int CTL_SPLIT_LSB = 4;

endpackage

// File: rtl/mcam_hostregs.sv
module mcam_hostregs
   import mcam_pkg::*;
#(
   parameter int HOST_W = 16,
   parameter int WORDS  = 4,
   parameter int AW     = 4,
   parameter int DW     = HOST_W * WORDS,
   parameter int WIDX   = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_grp,
   input  logic [WIDX-1:0]   wr_idx,
   input  logic [HOST_W-1:0] wr_data,
   output logic [DW-1:0]     key_q,
   output logic [DW-1:0]     mska_q,
   output logic [DW-1:0]     mskb_q,
   output logic [HOST_W-1:0] ctl_q,
   output logic [AW-1:0]     ptr_q,
   output logic              trig_q,
   output logic              ent_we,
   output logic              st_we,
   output logic [1:0]        st_code
);

   logic starts_search;

   always_comb begin
      starts_search = 1'b0;
      if (wr_en) begin
         if (wr_grp == GRP_KEY || wr_grp == GRP_MSKA ||
             wr_grp == GRP_MSKB || wr_grp == GRP_CTL)
            starts_search = 1'b1;
         else if (wr_grp == GRP_CMD && wr_data[1:0] == OP_SEARCH)
            starts_search = 1'b1;
      end
   end

   assign ent_we  = wr_en && (wr_grp == GRP_ENT);
   assign st_we   = wr_en && (wr_grp == GRP_CMD) && (wr_data[1:0] == OP_SETST);
   assign st_code = wr_data[3:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q  <= '0;
         mska_q <= '0;
         mskb_q <= '0;
         ctl_q  <= '0;
         ptr_q  <= '0;
         trig_q <= 1'b0;
      end else begin
         trig_q <= starts_search;
         if (wr_en) begin
            for (int w = 0; w < WORDS; w++) begin
               if (wr_idx == WIDX'(w)) begin
                  if (wr_grp == GRP_KEY)  key_q [w*HOST_W +: HOST_W] <= wr_data;
                  if (wr_grp == GRP_MSKA) mska_q[w*HOST_W +: HOST_W] <= wr_data;
                  if (wr_grp == GRP_MSKB) mskb_q[w*HOST_W +: HOST_W] <= wr_data;
               end
            end
            if (wr_grp == GRP_CTL) ctl_q <= wr_data;
            if (wr_grp == GRP_PTR) ptr_q <= wr_data[AW-1:0];
         end
      end
   end

endmodule

// File: rtl/mcam_array.sv
module mcam_array
   import mcam_pkg::*;
#(
   parameter int HOST_W = 16,
   parameter int WORDS  = 4,
   parameter int DEPTH  = 16,
   parameter int DW     = HOST_W * WORDS,
   parameter int WIDX   = $clog2(WORDS),
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ent_we,
   input  logic [AW-1:0]     ptr,
   input  logic [WIDX-1:0]   widx,
   input  logic [HOST_W-1:0] wdata,
   input  logic [HOST_W-1:0] wkeep,
   input  logic              st_we,
   input  logic [1:0]        st_code,
   input  logic [DW-1:0]     key,
   input  logic [DW-1:0]     care,
   input  logic [AW-1:0]     sel_idx,
   output logic [DEPTH-1:0]  hit_vec,
   output logic [DW-1:0]     ptr_data,
   output logic [1:0]        ptr_state,
   output logic [DW-1:0]     sel_data
);

   logic [DW-1:0] data_arr  [DEPTH];
   logic [1:0]    state_arr [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [DW-1:0] dat_q;
      logic [1:0]    st_q;
      logic          sel_here;

      assign sel_here = (ptr == AW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dat_q <= '0;
            st_q  <= ST_EMPTY;
         end else begin
            if (ent_we && sel_here) begin
               for (int w = 0; w < WORDS; w++) begin
                  if (widx == WIDX'(w))
                     dat_q[w*HOST_W +: HOST_W] <=
                        (dat_q[w*HOST_W +: HOST_W] & wkeep) | (wdata & ~wkeep);
               end
            end
            if (st_we && sel_here)
               st_q <= st_code;
         end
      end

      assign hit_vec[g]   = (st_q == ST_VALID) && (((dat_q ^ key) & care) == '0);
      assign data_arr[g]  = dat_q;
      assign state_arr[g] = st_q;
   end

   assign ptr_data  = data_arr[ptr];
   assign ptr_state = state_arr[ptr];
   assign sel_data  = data_arr[sel_idx];

endmodule

// File: rtl/mcam_resolve.sv
module mcam_resolve #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] hit_vec,
   output logic             any_hit,
   output logic             many_hit,
   output logic [AW-1:0]    first_idx
);

   assign any_hit  = |hit_vec;
   // clearing the lowest set bit leaves something only if two or more are set
   assign many_hit = |(hit_vec & (hit_vec - 1'b1));

   always_comb begin
      first_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (hit_vec[i]) first_idx = AW'(i);
      end
   end

endmodule

// File: rtl/mcam_core.sv
module mcam_core
   import mcam_pkg::*;
#(
   parameter int HOST_W = 16,
   parameter int WORDS  = 4,
   parameter int DEPTH  = 16
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [3+$clog2(WORDS)-1:0]             wr_addr,
   input  logic [HOST_W-1:0]                      wr_data,
   input  logic [3+$clog2(WORDS)-1:0]             rd_addr,
   output logic [HOST_W-1:0]                      rd_data,
   output logic                                   match_o,
   output logic                                   multi_o,
   output logic [$clog2(DEPTH)-1:0]               match_addr_o,
   output logic [HOST_W*WORDS-1:0]                assoc_o
);

   localparam int DW      = HOST_W * WORDS;
   localparam int WIDX    = $clog2(WORDS);
   localparam int AW      = $clog2(DEPTH);
   localparam int HADDR_W = 3 + WIDX;

   if (WORDS < 2 || (1 << WIDX) != WORDS)
      $error("WORDS must be a power of two of at least 2");
   if (DEPTH < 2 || (1 << AW) != DEPTH)
      $error("DEPTH must be a power of two of at least 2");
   if (HOST_W < AW + 2)
      $error("HOST_W too narrow for the status word");
   if (HOST_W < CTL_SPLIT_LSB + WIDX)
      $error("HOST_W too narrow for the control word");

   logic [2:0]        wr_grp, rd_grp;
   logic [WIDX-1:0]   wr_idx, rd_idx;
   logic [DW-1:0]     key_q, mska_q, mskb_q;
   logic [HOST_W-1:0] ctl_q;
   logic [AW-1:0]     ptr_q;
   logic              trig_q, ent_we, st_we;
   logic [1:0]        st_code;

   assign wr_grp = wr_addr[HADDR_W-1 -: 3];
   assign wr_idx = wr_addr[WIDX-1:0];
   assign rd_grp = rd_addr[HADDR_W-1 -: 3];
   assign rd_idx = rd_addr[WIDX-1:0];

   mcam_hostregs #(.HOST_W(HOST_W), .WORDS(WORDS), .AW(AW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_grp  (wr_grp),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .key_q   (key_q),
      .mska_q  (mska_q),
      .mskb_q  (mskb_q),
      .ctl_q   (ctl_q),
      .ptr_q   (ptr_q),
      .trig_q  (trig_q),
      .ent_we  (ent_we),
      .st_we   (st_we),
      .st_code (st_code)
   );

   function automatic logic [DW-1:0] pick_mask(input logic [1:0] sel,
                                               input logic [DW-1:0] a,
                                               input logic [DW-1:0] b);
      case (sel)
         2'd1:    return a;
         2'd2:    return b;
         2'd3:    return a | b;
         default: return '0;
      endcase
   endfunction

   logic [DW-1:0]     cmp_mask, wr_mask, split_care, care;
   logic [HOST_W-1:0] wkeep;
   logic [WIDX-1:0]   split_n;

   assign cmp_mask = pick_mask(ctl_q[CTL_CSEL_LSB +: 2], mska_q, mskb_q);
   assign wr_mask  = pick_mask(ctl_q[CTL_WSEL_LSB +: 2], mska_q, mskb_q);
   assign wkeep    = wr_mask[int'(wr_idx)*HOST_W +: HOST_W];
   assign split_n  = ctl_q[CTL_SPLIT_LSB +: WIDX];

   for (genvar w = 0; w < WORDS; w++) begin : g_split
      assign split_care[w*HOST_W +: HOST_W] =
         ((w + int'(split_n)) < WORDS) ? {HOST_W{1'b1}} : {HOST_W{1'b0}};
   end

   assign care = split_care & ~cmp_mask;

   logic [DEPTH-1:0] hit_vec;
   logic [DW-1:0]    ptr_data, sel_data;
   logic [1:0]       ptr_state;
   logic             any_hit, many_hit;
   logic [AW-1:0]    first_idx;

   mcam_array #(.HOST_W(HOST_W), .WORDS(WORDS), .DEPTH(DEPTH)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .ent_we    (ent_we),
      .ptr       (ptr_q),
      .widx      (wr_idx),
      .wdata     (wr_data),
      .wkeep     (wkeep),
      .st_we     (st_we),
      .st_code   (st_code),
      .key       (key_q),
      .care      (care),
      .sel_idx   (first_idx),
      .hit_vec   (hit_vec),
      .ptr_data  (ptr_data),
      .ptr_state (ptr_state),
      .sel_data  (sel_data)
   );

   mcam_resolve #(.DEPTH(DEPTH)) u_resolve (
      .hit_vec   (hit_vec),
      .any_hit   (any_hit),
      .many_hit  (many_hit),
      .first_idx (first_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_o      <= 1'b0;
         multi_o      <= 1'b0;
         match_addr_o <= '0;
         assoc_o      <= '0;
      end else if (trig_q) begin
         match_o      <= any_hit;
         multi_o      <= many_hit;
         match_addr_o <= any_hit ? first_idx : '0;
         assoc_o      <= any_hit ? (sel_data & ~care) : '0;
      end
   end

   logic [HOST_W-1:0] status_word;

   always_comb begin
      status_word             = '0;
      status_word[HOST_W-1]   = match_o;
      status_word[HOST_W-2]   = multi_o;
      status_word[AW-1:0]     = match_addr_o;
   end

   always_comb begin
      case (rd_grp)
         GRP_KEY:   rd_data = key_q [int'(rd_idx)*HOST_W +: HOST_W];
         GRP_MSKA:  rd_data = mska_q[int'(rd_idx)*HOST_W +: HOST_W];
         GRP_MSKB:  rd_data = mskb_q[int'(rd_idx)*HOST_W +: HOST_W];
         GRP_CTL:   rd_data = ctl_q;
         GRP_PTR:   rd_data = HOST_W'(ptr_q);
         GRP_ENT:   rd_data = ptr_data[int'(rd_idx)*HOST_W +: HOST_W];
         GRP_CMD:   rd_data = status_word;
         default:   rd_data = HOST_W'(ptr_state);
      endcase
   end

endmodule

// File: rtl/mcam_core_chk.sv
module mcam_core_chk #(
   parameter int HOST_W = 16,
   parameter int WORDS  = 4,
   parameter int DEPTH  = 16
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic [3+$clog2(WORDS)-1:0]    wr_addr,
   input logic [3+$clog2(WORDS)-1:0]    rd_addr,
   input logic [HOST_W-1:0]             rd_data,
   input logic                          match_o,
   input logic                          multi_o,
   input logic [$clog2(DEPTH)-1:0]      match_addr_o,
   input logic [HOST_W*WORDS-1:0]       assoc_o,
   input logic                          trig_q
);

   localparam int HADDR_W = 3 + $clog2(WORDS);

   p_multi_needs_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      multi_o |-> match_o);

   p_quiet_when_missed_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !match_o |-> (match_addr_o == '0 && assoc_o == '0 && !multi_o));

   p_hold_between_searches_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_q |=> $stable({match_o, multi_o, match_addr_o, assoc_o}));

   p_auto_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[HADDR_W-1 -: 3] <= 3'd3) |=> trig_q);

   p_status_mirrors_pins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[HADDR_W-1 -: 3] == 3'd6) |->
         (rd_data[HOST_W-1] == match_o && rd_data[HOST_W-2] == multi_o));

endmodule

bind mcam_core mcam_core_chk #(.HOST_W(HOST_W), .WORDS(WORDS), .DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .rd_addr      (rd_addr),
   .rd_data      (rd_data),
   .match_o      (match_o),
   .multi_o      (multi_o),
   .match_addr_o (match_addr_o),
   .assoc_o      (assoc_o),
   .trig_q       (trig_q)
);

// File: tb/mcam_core_tb.sv
module mcam_core_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        match_o, multi_o;
   logic [3:0]  match_addr_o;
   logic [63:0] assoc_o;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   mcam_core u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .rd_addr      (rd_addr),
      .rd_data      (rd_data),
      .match_o      (match_o),
      .multi_o      (multi_o),
      .match_addr_o (match_addr_o),
      .assoc_o      (assoc_o)
   );

   // reference state
   logic [63:0] m_ent [16];
   logic [1:0]  m_st  [16];
   logic [63:0] m_key, m_ma, m_mb;
   logic [15:0] m_ctl;
   logic [3:0]  m_ptr;
   logic        e_match, e_multi;
   logic [3:0]  e_addr;
   logic [63:0] e_assoc;

   function automatic logic [63:0] f_mask(input logic [1:0] sel);
      case (sel)
         2'd1:    return m_ma;
         2'd2:    return m_mb;
         2'd3:    return m_ma | m_mb;
         default: return 64'd0;
      endcase
   endfunction

   function automatic logic [63:0] f_care();
      logic [63:0] c;
      c = ~f_mask(m_ctl[1:0]);
      for (int w = 0; w < 4; w++)
         if (w >= 4 - int'(m_ctl[5:4])) c[w*16 +: 16] = 16'h0;
      return c;
   endfunction

   task automatic f_search();
      logic [63:0] c;
      int n;
      c = f_care();
      n = 0;
      e_match = 1'b0; e_addr = 4'd0; e_assoc = 64'd0;
      for (int i = 0; i < 16; i++) begin
         if (m_st[i] == 2'b00 && ((m_ent[i] ^ m_key) & c) == 64'd0) begin
            if (n == 0) begin
               e_match = 1'b1;
               e_addr  = 4'(i);
               e_assoc = m_ent[i] & ~c;
            end
            n++;
         end
      end
      e_multi = (n >= 2);
   endtask

   task automatic apply_model(input logic [2:0] g, input int ix, input logic [15:0] d);
      logic [63:0] wm;
      case (g)
         3'd0: m_key[ix*16 +: 16] = d;
         3'd1: m_ma [ix*16 +: 16] = d;
         3'd2: m_mb [ix*16 +: 16] = d;
         3'd3: m_ctl = d;
         3'd4: m_ptr = d[3:0];
         3'd5: begin
            wm = f_mask(m_ctl[3:2]);
            m_ent[m_ptr][ix*16 +: 16] =
               (m_ent[m_ptr][ix*16 +: 16] & wm[ix*16 +: 16]) | (d & ~wm[ix*16 +: 16]);
         end
         3'd6: if (d[1:0] == 2'b01) m_st[m_ptr] = d[3:2];
         default: ;
      endcase
      if (g <= 3'd3 || (g == 3'd6 && d[1:0] == 2'b00)) f_search();
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_out();
      chk("R6 match flag", 64'(match_o), 64'(e_match));
      chk("R7 multi flag", 64'(multi_o), 64'(e_multi));
      chk("R6 match address", 64'(match_addr_o), 64'(e_addr));
      chk("R10 assoc data", assoc_o, e_assoc);
   endtask

   task automatic hw(input logic [2:0] g, input int ix, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = {g, 2'(ix)}; wr_data = d;
      apply_model(g, ix, d);
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      check_out();
   endtask

   task automatic rd(input logic [2:0] g, input int ix, output logic [15:0] v);
      @(negedge clk);
      rd_addr = {g, 2'(ix)};
      #1 v = rd_data;
   endtask

   function automatic logic [15:0] pool();
      case ($urandom % 4)
         0: return 16'h0000;
         1: return 16'hFFFF;
         2: return 16'hA5A5;
         default: return 16'h1234;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) begin m_ent[i] = '0; m_st[i] = 2'b01; end
      m_key = '0; m_ma = '0; m_mb = '0; m_ctl = '0; m_ptr = '0;
      e_match = 0; e_multi = 0; e_addr = 0; e_assoc = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 match after reset", 64'(match_o), 64'd0);
      chk("R1 multi after reset", 64'(multi_o), 64'd0);
      chk("R1 addr after reset", 64'(match_addr_o), 64'd0);
      rd(3'd7, 0, v); chk("R1 entry state Empty", 64'(v), 64'd1);
      rd(3'd0, 3, v); chk("R1 key zero", 64'(v), 64'd0);

      // R2 register readback
      hw(3'd1, 2, 16'hBEEF);
      rd(3'd1, 2, v); chk("R2 mask A word readback", 64'(v), 64'hBEEF);
      hw(3'd1, 2, 16'h0000);
      hw(3'd4, 0, 16'h0009);
      rd(3'd4, 0, v); chk("R2 pointer readback", 64'(v), 64'h9);

      // entries 3, 5 Valid and 7 Skip with identical data
      for (int e = 3; e <= 7; e += 2) begin
         hw(3'd4, 0, 16'(e));
         for (int w = 0; w < 4; w++) hw(3'd5, w, 16'h1111 * 16'(w + 1));
      end
      hw(3'd4, 0, 16'd3); hw(3'd6, 0, 16'h0001);
      hw(3'd4, 0, 16'd5); hw(3'd6, 0, 16'h0001);
      hw(3'd4, 0, 16'd7); hw(3'd6, 0, 16'h0009);
      rd(3'd5, 1, v); chk("R3 entry word readback", 64'(v), 64'h2222);
      rd(3'd7, 0, v); chk("R4 Skip code readback", 64'(v), 64'h2);
      for (int w = 0; w < 4; w++) hw(3'd0, w, 16'h1111 * 16'(w + 1));
      chk("R6 lowest index wins", 64'(match_addr_o), 64'd3);
      chk("R7 two valid hits", 64'(multi_o), 64'd1);

      // R4/R5: state change alone keeps results, explicit search updates
      hw(3'd4, 0, 16'd3); hw(3'd6, 0, 16'h000D);
      chk("R5 held over state write", 64'(match_addr_o), 64'd3);
      hw(3'd6, 0, 16'h0000);
      chk("R4 RAM entry excluded", 64'(match_addr_o), 64'd5);
      chk("R4 single hit left", 64'(multi_o), 64'd0);
      hw(3'd4, 0, 16'd5); hw(3'd6, 0, 16'h0005); hw(3'd6, 0, 16'h0000);
      chk("R11 no hit flag", 64'(match_o), 64'd0);
      chk("R11 no hit address", 64'(match_addr_o), 64'd0);

      // R3 write mask
      hw(3'd3, 0, 16'h0004);
      hw(3'd1, 0, 16'h00FF);
      hw(3'd4, 0, 16'd3); hw(3'd5, 0, 16'hABCD);
      rd(3'd5, 0, v); chk("R3 masked write keeps bits", 64'(v), 64'hAB11);
      hw(3'd3, 0, 16'h0000);
      hw(3'd5, 0, 16'h1111); hw(3'd5, 3, 16'h9999);
      hw(3'd6, 0, 16'h0001);

      // R9/R10 split: top word is associated data
      hw(3'd3, 0, 16'h0010);
      chk("R9 split hit", 64'(match_addr_o), 64'd3);
      chk("R10 assoc top word", assoc_o, 64'h9999_0000_0000_0000);

      // R8 compare mask B over word 0
      hw(3'd3, 0, 16'h0002);
      hw(3'd2, 0, 16'hFFFF);
      hw(3'd0, 0, 16'h0000);
      hw(3'd0, 3, 16'h9999);
      chk("R8 masked compare hit", 64'(match_o), 64'd1);
      chk("R10 assoc masked bits", assoc_o, 64'h0000_0000_0000_1111);
      rd(3'd6, 0, v); chk("R12 status word", 64'(v), 64'h8003);

      // random mix
      for (int it = 0; it < 500; it++) begin
         int r;
         r = int'($urandom % 16);
         if (r < 5)       hw(3'd5, int'($urandom % 4), pool());
         else if (r < 7)  hw(3'd6, 0, {12'h0, (($urandom % 3) == 0) ? 2'($urandom) : 2'b00, 2'b01});
         else if (r < 11) hw(3'd0, int'($urandom % 4), pool());
         else if (r == 11) hw(3'd1, int'($urandom % 4), 16'($urandom & $urandom & $urandom));
         else if (r == 12) hw(3'd2, int'($urandom % 4), 16'($urandom & $urandom & $urandom));
         else if (r == 13) hw(3'd3, 0, {10'h0, 2'($urandom), 2'($urandom), 2'($urandom)});
         else if (r == 14) hw(3'd4, 0, 16'($urandom % 16));
         else begin
            hw(3'd6, 0, 16'h0000);
            rd(3'd6, 0, v);
            chk("R12 status random", 64'(v), 64'({e_match, e_multi, 10'h0, e_addr}));
            rd(3'd5, int'($urandom % 4), v);
            chk("R3 entry random readback", 64'(v), 64'(m_ent[m_ptr][int'(rd_addr[1:0])*16 +: 16]));
            rd(3'd7, 0, v);
            chk("R4 state random readback", 64'(v), 64'(m_st[m_ptr]));
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule